// File: doc/BRIEF.md
# Sticky Fault Status Register with Sub-Word Access

This block holds the sticky fault flags that a processor core reports, packed into one 32-bit register at a fixed bus offset. The register has three parts. A usage-fault half occupies bits 31:16. A bus-fault byte occupies bits 15:8. A memory-protection byte occupies bits 7:0. Single-cycle event pulses from the core set the flags. Software reads the flags and clears them by writing ones.

A memory-mapped port reaches the register with byte, halfword or word accesses. Each access touches only the byte lanes that its size and address select, so one handler can clear its own part without disturbing the others. Two trap-enable inputs decide whether divide-by-zero and ordinary unaligned-access events are recorded. The block also drives one pending output per fault class.

Top module: `fault_status_reg`

## Requirements
- R1: After reset every flag is 0, `acc_rdata` is 0, and all three pending outputs are low.
- R2: `acc_size` encodes 0 = byte, 1 = halfword, 2 = word. The register sits at offset 0x28. A byte access at 0x28+k reaches byte lane k. A halfword access at 0x28 reaches lanes 1:0, and one at 0x2A reaches lanes 3:2. A word access at 0x28 reaches all four lanes. Write data and read data sit on their natural lanes (lane k is bits 8k+7:8k). The unselected lanes of `acc_rdata` read 0. Read data shows the register as it was before the clock edge on which the read is sampled, and it is valid from that edge until the next read.
- R3: An access to another word, a misaligned halfword (odd address), a word access that is not at 0x28, or size 3 changes no flag, and a read of this kind returns 0.
- R4: The usage-fault flags are divide-by-zero at bit 25, unaligned at 24, no-coprocessor at 19, bad-PC-load at 18, bad-state at 17 and undefined-instruction at 16. Bits 31:26 and 23:20 always read 0.
- R5: A fault event sets its flag on the next clock edge. The flag stays set until software clears it.
- R6: Writing 1 to a flag in a selected lane clears it. Writing 0, or writing to an unselected lane, leaves the flag unchanged.
- R7: `divz_evt` sets bit 25 only when `divz_trap_en` is 1.
- R8: `unal_evt` sets bit 24 only when `unal_trap_en` is 1. `unal_wide_evt` (an unaligned multi-word or doubleword access) sets bit 24 whatever the enable is.
- R9: `bus_evt[i]` sets bit 8+i and `mm_evt[i]` sets bit i. Bit 7 of each byte is its address-valid flag. Bit 6 of both bytes and bit 2 of the memory-protection byte are reserved: events and writes leave them at 0.
- R10: When a hardware set and a write-1 clear reach the same flag in the same cycle, the flag ends set.
- R11: `usage_pend` is the OR of bits 31:16, `bus_pend` is the OR of bits 14:8, and `mm_pend` is the OR of bits 6:0. An address-valid flag on its own does not raise a pending output. Each output follows the register in the same cycle, so it changes right after the clock edge that updates a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data, aligned to byte lanes |
| acc_rdata | output | 32 | Registered read data, aligned to byte lanes |
| mm_evt | input | 8 | Memory-protection event pulses, one per bit |
| bus_evt | input | 8 | Bus-fault event pulses, one per bit |
| divz_evt | input | 1 | Divide by zero reported |
| unal_evt | input | 1 | Unaligned single access reported |
| unal_wide_evt | input | 1 | Unaligned multi-word or doubleword access reported |
| nocop_evt | input | 1 | Coprocessor access attempted |
| badpc_evt | input | 1 | Illegal PC load on return |
| badstate_evt | input | 1 | Illegal execution-state use |
| undef_evt | input | 1 | Undefined instruction |
| divz_trap_en | input | 1 | Enables recording of divide-by-zero |
| unal_trap_en | input | 1 | Enables recording of unaligned single accesses |
| usage_pend | output | 1 | Any usage flag set |
| bus_pend | output | 1 | Any bus-fault flag set, address-valid excluded |
| mm_pend | output | 1 | Any memory-protection flag set, address-valid excluded |

## Verification
Events and write-1 clears take effect on the first clock edge after they are presented. The pending outputs follow within that same cycle, and read data for a request sampled on an edge is valid right after that edge. The bench presents inputs at the falling edge. At the next falling edge it advances a behavioural model by one step and compares `acc_rdata` and the three pending outputs, so every result is checked in the first half-cycle in which it is due. Directed reads after each scenario also check hand-derived register images at the lanes that the requirements name.

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int ADDR_W  = 12,
  parameter int REG_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic [7:0]        mm_evt,
  input  logic [7:0]        bus_evt,
  input  logic              divz_evt,
  input  logic              unal_evt,
  input  logic              unal_wide_evt,
  input  logic              nocop_evt,
  input  logic              badpc_evt,
  input  logic              badstate_evt,
  input  logic              undef_evt,
  input  logic              divz_trap_en,
  input  logic              unal_trap_en,
  output logic              usage_pend,
  output logic              bus_pend,
  output logic              mm_pend
);

  localparam logic [ADDR_W-1:0] OFS_V   = ADDR_W'(REG_OFS);
  localparam logic [7:0]        MM_IMPL = 8'hBB;
  localparam logic [7:0]        BF_IMPL = 8'hBF;
  localparam logic [15:0]       UF_IMPL = 16'h030F;
  localparam logic [31:0]       IMPL    = {UF_IMPL, BF_IMPL, MM_IMPL};

  logic [31:0] stat_q;
  logic [3:0]  lane;
  logic [31:0] bmask, clr, set;
  logic        word_hit;

  assign word_hit = (acc_addr[ADDR_W-1:2] == OFS_V[ADDR_W-1:2]);

  always_comb begin
    lane = 4'b0000;
    case (acc_size)
      2'd0: lane = 4'b0001 << acc_addr[1:0];
      2'd1: if (!acc_addr[0]) lane = acc_addr[1] ? 4'b1100 : 4'b0011;
      2'd2: if (acc_addr[1:0] == 2'b00) lane = 4'b1111;
      default: lane = 4'b0000;
    endcase
    if (!acc_en || !word_hit) lane = 4'b0000;
  end

  assign bmask = {{8{lane[3]}}, {8{lane[2]}}, {8{lane[1]}}, {8{lane[0]}}};
  assign clr   = acc_wr ? (acc_wdata & bmask) : 32'h0;

  assign set = {6'b0,
                divz_evt & divz_trap_en,
                unal_wide_evt | (unal_evt & unal_trap_en),
                4'b0,
                nocop_evt, badpc_evt, badstate_evt, undef_evt,
                bus_evt,
                mm_evt} & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 32'h0;
    else        stat_q <= ((stat_q & ~clr) | set) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_rdata <= 32'h0;
    else if (acc_en && !acc_wr) acc_rdata <= stat_q & bmask;
  end

  assign usage_pend = |stat_q[31:16];
  assign bus_pend   = |stat_q[14:8];
  assign mm_pend    = |stat_q[6:0];

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata & ~IMPL) == 32'h0);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[16] && !(acc_en && acc_wr) |=> stat_q[16]);

  // R7
  divz_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divz_evt && !divz_trap_en && !stat_q[25] |=> !stat_q[25]);

  // R8
  unal_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unal_wide_evt |=> stat_q[24]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divz_evt && divz_trap_en |=> stat_q[25]);

  // R3
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_wr && (acc_addr[ADDR_W-1:2] != OFS_V[ADDR_W-1:2])
    |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R11
  mm_pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mm_pend) |-> $past(|mm_evt[6:0]));

endmodule

// File: tb/tb_fault_status_reg.sv
`timescale 1ns/1ps
module tb_fault_status_reg;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acc_en = 0, acc_wr = 0;
  logic [1:0]  acc_size = 0;
  logic [11:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic [7:0]  mm_evt = 0, bus_evt = 0;
  logic divz_evt = 0, unal_evt = 0, unal_wide_evt = 0, nocop_evt = 0;
  logic badpc_evt = 0, badstate_evt = 0, undef_evt = 0;
  logic divz_trap_en = 0, unal_trap_en = 0;
  logic usage_pend, bus_pend, mm_pend;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic [31:0] m_stat = 0, m_rd = 0, got;

  fault_status_reg dut (.*);

  always #2 clk = ~clk;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endfunction

  function automatic logic [3:0] ref_lanes(logic en, logic [11:0] a, logic [1:0] s);
    int off;
    off = int'(a) - 'h28;
    if (!en || off < 0 || off > 3) return 4'b0;
    if (s == 2'd0) return 4'(1 << off);
    if (s == 2'd1 && off == 0) return 4'b0011;
    if (s == 2'd1 && off == 2) return 4'b1100;
    if (s == 2'd2 && off == 0) return 4'b1111;
    return 4'b0;
  endfunction

  task automatic model_step();
    logic [3:0] ln;
    logic [31:0] nxt;
    ln = ref_lanes(acc_en, acc_addr, acc_size);
    nxt = m_stat;
    if (acc_en && !acc_wr) begin
      m_rd = 0;
      for (int b = 0; b < 32; b++) if (ln[b/8]) m_rd[b] = m_stat[b];
    end
    if (acc_en && acc_wr)
      for (int b = 0; b < 32; b++) if (ln[b/8] && acc_wdata[b]) nxt[b] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (mm_evt[i] && i != 6 && i != 2) nxt[i] = 1'b1;
      if (bus_evt[i] && i != 6) nxt[8+i] = 1'b1;
    end
    if (undef_evt) nxt[16] = 1'b1;
    if (badstate_evt) nxt[17] = 1'b1;
    if (badpc_evt) nxt[18] = 1'b1;
    if (nocop_evt) nxt[19] = 1'b1;
    if (unal_wide_evt || (unal_evt && unal_trap_en)) nxt[24] = 1'b1;
    if (divz_evt && divz_trap_en) nxt[25] = 1'b1;
    m_stat = nxt;
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    chk({cur_req, " rdata"}, acc_rdata, m_rd);
    chk("R11 usage_pend", 32'(usage_pend), 32'(|m_stat[31:16]));
    chk("R11 bus_pend", 32'(bus_pend), 32'(|m_stat[14:8]));
    chk("R11 mm_pend", 32'(mm_pend), 32'(|m_stat[6:0]));
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] s, logic [31:0] d);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_size = s; acc_wdata = d;
    tick();
    acc_en = 0; acc_wr = 0; acc_wdata = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] s);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_size = s;
    tick();
    got = acc_rdata;
    acc_en = 0;
  endtask

  task automatic clear_evts();
    mm_evt = 0; bus_evt = 0; divz_evt = 0; unal_evt = 0; unal_wide_evt = 0;
    nocop_evt = 0; badpc_evt = 0; badstate_evt = 0; undef_evt = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", acc_rdata, 0);
    chk("R1 pends", {29'b0, usage_pend, bus_pend, mm_pend}, 0);
    rst_n = 1;
    rd('h28, 2); chk("R1 word after reset", got, 0);

    cur_req = "R5";
    undef_evt = 1; nocop_evt = 1; tick(); clear_evts();
    chk("R11 usage_pend after event", 32'(usage_pend), 1);
    rd('h28, 2); chk("R4 usage layout", got, 32'h0009_0000);
    cur_req = "R2";
    rd('h2A, 1); chk("R2 half 0x2A", got, 32'h0009_0000);
    rd('h2A, 0); chk("R2 byte 0x2A", got, 32'h0009_0000);
    rd('h2B, 0); chk("R2 byte 0x2B", got, 0);
    rd('h28, 1); chk("R2 half 0x28", got, 0);

    cur_req = "R9";
    mm_evt = 8'hFF; tick(); clear_evts();
    bus_evt = 8'h80; tick(); clear_evts();
    chk("R11 addr-valid alone", 32'(bus_pend), 0);
    chk("R11 mm_pend", 32'(mm_pend), 1);
    rd('h29, 0); chk("R2 byte 0x29", got, 32'h0000_8000);
    rd('h28, 0); chk("R9 mm reserved bits", got, 32'h0000_00BB);
    rd('h28, 1); chk("R2 half 0x28", got, 32'h0000_80BB);
    rd('h28, 2); chk("R2 word", got, 32'h0009_80BB);

    cur_req = "R6";
    wr('h28, 2, 0); rd('h28, 2); chk("R6 write zero", got, 32'h0009_80BB);
    wr('h2A, 1, 32'h0001_0000); rd('h28, 2); chk("R6 half clear", got, 32'h0008_80BB);
    wr('h29, 0, 32'hFFFF_FFFF); rd('h28, 2); chk("R6 lane-limited clear", got, 32'h0008_00BB);

    cur_req = "R3";
    wr('h29, 1, 32'hFFFF_FFFF);
    wr('h2A, 2, 32'hFFFF_FFFF);
    wr('h2C, 2, 32'hFFFF_FFFF);
    wr('h28, 3, 32'hFFFF_FFFF);
    rd('h28, 2); chk("R3 ignored writes", got, 32'h0008_00BB);
    rd('h24, 2); chk("R3 other word read", got, 0);
    rd('h29, 1); chk("R3 misaligned read", got, 0);

    cur_req = "R7";
    divz_evt = 1; tick(); clear_evts();
    rd('h28, 2); chk("R7 trap off", got, 32'h0008_00BB);
    divz_trap_en = 1; divz_evt = 1; tick(); clear_evts();
    rd('h28, 2); chk("R7 trap on", got, 32'h0208_00BB);

    cur_req = "R8";
    unal_evt = 1; tick(); clear_evts();
    rd('h28, 2); chk("R8 trap off", got, 32'h0208_00BB);
    unal_wide_evt = 1; tick(); clear_evts();
    rd('h28, 2); chk("R8 wide ignores enable", got, 32'h0308_00BB);
    wr('h2B, 0, 32'h0100_0000);
    rd('h28, 2); chk("R8 cleared", got, 32'h0208_00BB);
    unal_trap_en = 1; unal_evt = 1; tick(); clear_evts();
    rd('h28, 2); chk("R8 trap on", got, 32'h0308_00BB);

    cur_req = "R10";
    divz_evt = 1; wr('h28, 2, 32'hFFFF_FFFF); clear_evts();
    rd('h28, 2); chk("R10 set wins", got, 32'h0200_0000);
    wr('h28, 2, 32'hFFFF_FFFF);
    chk("R11 all clear", {29'b0, usage_pend, bus_pend, mm_pend}, 0);

    cur_req = "R2 random";
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] addrs [6];
      addrs = '{12'h24, 12'h28, 12'h29, 12'h2A, 12'h2B, 12'h2C};
      acc_en = ($urandom % 3) != 0;
      acc_wr = $urandom % 2;
      acc_addr = addrs[$urandom % 6];
      acc_size = 2'($urandom % 4);
      acc_wdata = $urandom;
      divz_trap_en = $urandom % 2; unal_trap_en = $urandom % 2;
      mm_evt = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0;
      bus_evt = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0;
      divz_evt = ($urandom % 10) == 0; unal_evt = ($urandom % 10) == 0;
      unal_wide_evt = ($urandom % 20) == 0; nocop_evt = ($urandom % 16) == 0;
      badpc_evt = ($urandom % 16) == 0; badstate_evt = ($urandom % 16) == 0;
      undef_evt = ($urandom % 16) == 0;
      tick();
    end
    clear_evts(); acc_en = 0;
    tick();

    summary();
    $finish;
  end
endmodule